// File: doc/BRIEF.md
# Masked-Write Link Control Registers

This block is a small register slave on a 32-bit APB-style bus. It sits in the glue logic next to a PCIe controller core. It holds two control registers and one read-only status register. The control registers drive the core's device-type, LTSSM-enable, reset-grant and enhanced LTSSM-enable inputs. The status register shows the link-up flags and the LTSSM state that come back from the core.

Each write to a control register carries its own bit mask in the upper half-word of the write data. Software can therefore set or clear a single control bit in one bus write, with no read-modify-write sequence. The slave answers every transfer in its access phase with no wait states.

Top module: `lnk_ctl_regs`

## Requirements
- R1: On a write to a control register, lower bit n (n in 0..15) takes write-data bit n when write-data bit n+16 is 1.
- R2: On a write to a control register, lower bits whose mask bit (write-data bit n+16) is 0 keep their previous value.
- R3: The general control register decodes at byte offset 0x000, the hot-reset control register at 0x180 and the status register at 0x300.
- R4: General control bits 7:4 drive `dev_type_o`; writing 4 there selects root-complex mode.
- R5: General control bit 2 drives `ltssm_en_o`, and general control bit 3 drives `rst_grant_o`.
- R6: Hot-reset control bit 4 drives `ltssm_en_enh_o`.
- R7: A read of the status register returns `dll_link_up_i` on bit 17, `phy_link_up_i` on bit 16, `ltssm_state_i` on bits 4:0, and 0 on all other bits.
- R8: Reads of either control register return the stored lower 16 bits, with bits 31:16 read as 0.
- R9: A write to the status offset changes no control register and no output.
- R10: After reset all control bits are 0, so every control output is 0.
- R11: Reads of an unmapped offset return 0. Writes to an unmapped offset change nothing.
- R12: `pready_o` is 1 in every access phase, so every transfer completes in one access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte offset |
| pwdata_i | input | 32 | Write data: mask in 31:16, value in 15:0 |
| prdata_o | output | 32 | Read data |
| pready_o | output | 1 | Transfer complete |
| phy_link_up_i | input | 1 | Physical-layer link-up flag from the core |
| dll_link_up_i | input | 1 | Data-link-layer link-up flag from the core |
| ltssm_state_i | input | 5 | Current LTSSM state from the core |
| dev_type_o | output | 4 | Device type to the core |
| ltssm_en_o | output | 1 | LTSSM enable |
| rst_grant_o | output | 1 | Link-request reset grant |
| ltssm_en_enh_o | output | 1 | Enhanced LTSSM enable |

## Verification
The assertions assume a well-formed bus protocol:
- `penable_i` is only high while `psel_i` is high.
- Address and write data stay stable across the setup and access phases.

They also assume the status inputs are quiet during a status read. The bench drives each transfer as one setup cycle followed by one access cycle, with inputs changed just after a rising edge. It changes the status inputs only while the bus is idle.

// File: rtl/lnk_ctl_pkg.sv
package lnk_ctl_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CTRL_W   = DATA_W / 2;
  localparam int unsigned STATE_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_GEN  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_HOT  = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h300;

  // field positions the core decodes
  localparam int unsigned GEN_EN_BIT    = 2;
  localparam int unsigned GEN_GRANT_BIT = 3;
  localparam int unsigned GEN_TYPE_LSB  = 4;
  localparam int unsigned TYPE_W        = 4;
  localparam int unsigned HOT_ENH_BIT   = 4;
  localparam int unsigned STAT_PHY_BIT  = 16;
  localparam int unsigned STAT_DLL_BIT  = 17;
endpackage

// File: rtl/lnk_masked_reg.sv
module lnk_masked_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [2*W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] mask;
  logic [W-1:0] val;
  assign mask = wdata_i[2*W-1:W];
  assign val  = wdata_i[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= (q_o & ~mask) | (val & mask);
  end

  // R1
  p_masked_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o & $past(mask)) == ($past(val) & $past(mask))));
  // R2
  p_unmasked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (((q_o ^ $past(q_o)) & ~$past(mask)) == '0));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/lnk_rd_mux.sv
module lnk_rd_mux
  import lnk_ctl_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CTRL_W-1:0]  gen_i,
  input  logic [CTRL_W-1:0]  hot_i,
  input  logic               phy_up_i,
  input  logic               dll_up_i,
  input  logic [STATE_W-1:0] state_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word               = '0;
    stat_word[STATE_W-1:0]  = state_i;
    stat_word[STAT_PHY_BIT] = phy_up_i;
    stat_word[STAT_DLL_BIT] = dll_up_i;
  end

  always_comb begin
    unique case (addr_i)
      OFS_GEN:  rdata_o = {{(DATA_W-CTRL_W){1'b0}}, gen_i};
      OFS_HOT:  rdata_o = {{(DATA_W-CTRL_W){1'b0}}, hot_i};
      OFS_STAT: rdata_o = stat_word;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lnk_ctl_regs.sv
module lnk_ctl_regs
  import lnk_ctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  output logic [DATA_W-1:0]  prdata_o,
  output logic               pready_o,
  input  logic               phy_link_up_i,
  input  logic               dll_link_up_i,
  input  logic [STATE_W-1:0] ltssm_state_i,
  output logic [TYPE_W-1:0]  dev_type_o,
  output logic               ltssm_en_o,
  output logic               rst_grant_o,
  output logic               ltssm_en_enh_o
);
  logic              wr_acc, rd_acc;
  logic              gen_we, hot_we;
  logic [CTRL_W-1:0] gen_q, hot_q;

  assign wr_acc = psel_i & penable_i & pwrite_i;
  assign rd_acc = psel_i & penable_i & ~pwrite_i;
  assign gen_we = wr_acc & (paddr_i == OFS_GEN);
  assign hot_we = wr_acc & (paddr_i == OFS_HOT);

  lnk_masked_reg #(.W(CTRL_W)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(gen_we), .wdata_i(pwdata_i), .q_o(gen_q));

  lnk_masked_reg #(.W(CTRL_W)) u_hot (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(hot_we), .wdata_i(pwdata_i), .q_o(hot_q));

  lnk_rd_mux u_rd (
    .addr_i(paddr_i), .gen_i(gen_q), .hot_i(hot_q),
    .phy_up_i(phy_link_up_i), .dll_up_i(dll_link_up_i), .state_i(ltssm_state_i),
    .rdata_o(prdata_o));

  assign pready_o       = 1'b1;
  assign dev_type_o     = gen_q[GEN_TYPE_LSB +: TYPE_W];
  assign ltssm_en_o     = gen_q[GEN_EN_BIT];
  assign rst_grant_o    = gen_q[GEN_GRANT_BIT];
  assign ltssm_en_enh_o = hot_q[HOT_ENH_BIT];

  // R9: writes to status leave every control output unchanged
  p_stat_write_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && paddr_i == OFS_STAT) |=>
      ($stable(dev_type_o) && $stable(ltssm_en_o) && $stable(rst_grant_o) && $stable(ltssm_en_enh_o)));
  // R11: unmapped writes ignored
  p_unmapped_write_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && paddr_i != OFS_GEN && paddr_i != OFS_HOT) |=>
      ($stable(gen_q) && $stable(hot_q)));
  // R8: mask half reads as zero
  p_ctrl_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && (paddr_i == OFS_GEN || paddr_i == OFS_HOT)) |-> (prdata_o[DATA_W-1:CTRL_W] == '0));
  // R11: unmapped reads zero
  p_unmapped_read_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && paddr_i != OFS_GEN && paddr_i != OFS_HOT && paddr_i != OFS_STAT) |-> (prdata_o == '0));
  // R7: status bits track inputs
  p_stat_layout_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && paddr_i == OFS_STAT) |->
      (prdata_o[STAT_DLL_BIT] == dll_link_up_i && prdata_o[STAT_PHY_BIT] == phy_link_up_i &&
       prdata_o[STATE_W-1:0] == ltssm_state_i));
  // R12
  p_no_wait_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i) |-> pready_o);
endmodule

// File: tb/sim_lnk_ctl_regs.sv
module sim_lnk_ctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        phy_up = 1'b0, dll_up = 1'b0;
  logic [4:0]  state = '0;
  logic [3:0]  dev_type;
  logic        en, grant, enh;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_gen = '0, m_hot = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_ctl_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .phy_link_up_i(phy_up), .dll_link_up_i(dll_up), .ltssm_state_i(state),
    .dev_type_o(dev_type), .ltssm_en_o(en), .rst_grant_o(grant), .ltssm_en_enh_o(enh));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // monitor: compare read data in each access phase
  always @(negedge clk) begin
    if (psel && penable) check("R12 pready", {31'b0, pready}, 32'd1);
    if (psel && penable && !pwrite && exp_q.size() > 0)
      check(tag_q.pop_front(), prdata, exp_q.pop_front());
  end

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h000) m_gen = (m_gen & ~d[31:16]) | (d[15:0] & d[31:16]);
    if (a == 12'h180) m_hot = (m_hot & ~d[31:16]) | (d[15:0] & d[31:16]);
    xfer(1'b1, a, d);
  endtask

  task automatic apb_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer(1'b0, a, 32'h0);
  endtask

  task automatic chk_outs(input string req);
    check({req, " dev_type"}, {28'b0, dev_type}, {28'b0, m_gen[7:4]});
    check({req, " ltssm_en"}, {31'b0, en}, {31'b0, m_gen[2]});
    check({req, " grant"}, {31'b0, grant}, {31'b0, m_gen[3]});
    check({req, " enh"}, {31'b0, enh}, {31'b0, m_hot[4]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    chk_outs("R10 reset");
    apb_rd(12'h000, 32'h0, "R10 gen reset");
    apb_rd(12'h180, 32'h0, "R10 hot reset");

    apb_wr(12'h000, 32'h00F0_0040);
    chk_outs("R4 root-complex type");
    check("R4 type=4", {28'b0, dev_type}, 32'd4);
    apb_rd(12'h000, 32'h0000_0040, "R8 R3 gen readback");

    apb_wr(12'h000, 32'h000C_FF0C);
    chk_outs("R5 R1 set en/grant");
    check("R5 en", {31'b0, en}, 32'd1);
    check("R5 grant", {31'b0, grant}, 32'd1);

    apb_wr(12'h000, 32'h0004_0000);
    chk_outs("R1 R2 clear en only");
    apb_wr(12'h000, 32'h0000_FFFF);
    chk_outs("R2 no mask no change");
    apb_rd(12'h000, {16'h0, m_gen}, "R2 gen readback");

    apb_wr(12'h180, 32'h0010_0010);
    chk_outs("R6 enh set");
    check("R6 enh", {31'b0, enh}, 32'd1);
    apb_rd(12'h180, 32'h0000_0010, "R3 R8 hot readback");

    phy_up = 1'b1; dll_up = 1'b1; state = 5'h11;
    apb_rd(12'h300, 32'h0003_0011, "R7 status up");
    phy_up = 1'b1; dll_up = 1'b0; state = 5'h05;
    apb_rd(12'h300, 32'h0001_0005, "R7 status phy only");
    phy_up = 1'b0; dll_up = 1'b1; state = 5'h1F;
    apb_rd(12'h300, 32'h0002_001F, "R7 status dll only");

    apb_wr(12'h300, 32'hFFFF_FFFF);
    chk_outs("R9 status write");
    apb_rd(12'h000, {16'h0, m_gen}, "R9 gen after status write");
    apb_rd(12'h180, {16'h0, m_hot}, "R9 hot after status write");

    apb_wr(12'h004, 32'hFFFF_FFFF);
    chk_outs("R11 unmapped write");
    apb_rd(12'h004, 32'h0, "R11 unmapped read");
    apb_rd(12'h184, 32'h0, "R11 unmapped read near hot");
    apb_rd(12'h000, {16'h0, m_gen}, "R11 gen after unmapped write");

    repeat (2) @(posedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule